// File: doc/BRIEF.md
# Serial Drive-Bay LED Shifter

This block drives the three serial lines of an external LED controller (a clock line, a load strobe and a data line) for a bank of drive bays. Every bay carries three status bits: activity, locate and fault. An update names a port and supplies its three bits. The block maps the port to an LED slot through a configurable table and keeps a packed pattern of three bits per slot. Every accepted update starts one complete serial frame toward the controller.

A frame has four parts in order. First come an optional number of leading clocks with load low. Then comes one clock with load high. Then the pattern is shifted out one bit per clock, least significant bit first. Last come an optional number of trailing clocks. Each clock is a low half followed by a high half, and each half lasts a parameterised number of system cycles (nominally 50 us). All lines rest high between frames. An update that arrives during a frame still changes the pattern, and it causes one further frame after the current one. The bits of a frame come from a copy of the pattern taken when that frame starts.

Top module: `sgpio_led_shifter`

## Requirements
- R1: Every clock of a frame holds led_clk low for HALF_CYCLES system cycles and then high for HALF_CYCLES system cycles, so a frame ends with led_clk high.
- R2: A frame opens with cfg_pre rising edges of led_clk (zero allowed) during which led_load is low and led_data is low.
- R3: After the leading clocks, led_load is high for exactly one rising edge of led_clk and is then low for the rest of the frame.
- R4: The data phase has 3 × cfg_nports rising edges; at the i-th of them led_data carries bit i of the frame's pattern copy (bit 0 first). led_data and led_load never change in the cycle where led_clk rises.
- R5: After the data phase come cfg_post rising edges with led_load and led_data low, and then all three lines return high.
- R6: The slot of port p is field p of cfg_slot_map (3 bits per field at default size, field p at bits [3p+2:3p]); the port's activity, locate and fault bits sit at pattern bits 3·slot+0, 3·slot+1 and 3·slot+2.
- R7: An accepted update writes all three bits of its slot to the new values and leaves every other slot's bits as they were.
- R8: After reset all three lines are high and no frame is sent until an update is accepted.
- R9: An update whose port index or mapped slot is at or above cfg_nports is rejected: upd_err is high in the cycle after the request, the pattern is unchanged and no frame starts.
- R10: Updates accepted while a frame runs cause exactly one more frame after the current one, carrying the pattern with all of those updates.
- R11: The bits of a frame are those of the pattern when the frame started; updates during the frame do not alter them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | One-cycle update request |
| upd_port | input | PW (4) | Port index of the update |
| upd_act | input | 1 | New activity bit |
| upd_loc | input | 1 | New locate bit |
| upd_flt | input | 1 | New fault bit |
| cfg_nports | input | PW (4) | Ports in use (values above MAX_PORTS act as MAX_PORTS); hold stable during frames |
| cfg_pre | input | CNT_W (4) | Leading clock count |
| cfg_post | input | CNT_W (4) | Trailing clock count |
| cfg_slot_map | input | MAX_PORTS·SW (24) | Port-to-slot table, SW bits per port |
| upd_err | output | 1 | Rejected-update pulse |
| led_clk | output | 1 | Serial clock to the LED controller |
| led_load | output | 1 | Load strobe to the LED controller |
| led_data | output | 1 | Serial data to the LED controller |

## Verification
upd_err is registered. The bench raises a request on a falling system edge and reads upd_err on the next falling edge, one cycle later. A frame starts two system edges after the request. It then lasts (cfg_pre + 1 + 3·cfg_nports + cfg_post) × 2 × HALF_CYCLES cycles. The bench waits that computed length plus a margin before it compares the recorded frame. Frame contents are recorded on each rising edge of led_clk, and the design never moves data or load at such an edge. The recorded edge count is therefore exact, and no check depends on the order of processes within a system cycle.

// File: rtl/sgpio_led_pkg.sv
package sgpio_led_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_PRE  = 3'd1,
      PH_LOAD = 3'd2,
      PH_DATA = 3'd3,
      PH_POST = 3'd4
   } frame_phase_t;

   // offsets of the three status bits inside one slot (R6)
   localparam int unsigned BIT_ACT = 0;
   localparam int unsigned BIT_LOC = 1;
   localparam int unsigned BIT_FLT = 2;
   localparam int unsigned BITS_PER_SLOT = 3;

endpackage

// File: rtl/sgpio_led_pattern.sv
module sgpio_led_pattern #(
   parameter int unsigned MAX_PORTS = 8,
   parameter int unsigned PW        = 4,
   parameter int unsigned SW        = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        upd_valid,
   input  logic [PW-1:0]               upd_port,
   input  logic [2:0]                  upd_status,
   input  logic [PW-1:0]               nports_eff,
   input  logic [MAX_PORTS*SW-1:0]     slot_map,
   output logic [3*MAX_PORTS-1:0]      pattern,
   output logic                        upd_accept,
   output logic                        upd_err
);
   import sgpio_led_pkg::*;

   logic [SW-1:0] slot_sel;
   logic          port_in_range;
   logic          slot_in_range;

   always_comb begin
      slot_sel = '0;
      for (int p = 0; p < int'(MAX_PORTS); p++) begin
         if (upd_port == PW'(p)) slot_sel = slot_map[p*SW +: SW];
      end
      port_in_range = (upd_port < nports_eff);
      slot_in_range = (PW'(slot_sel) < nports_eff);
   end

   assign upd_accept = upd_valid && port_in_range && slot_in_range;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upd_err <= 1'b0;
      else        upd_err <= upd_valid && !(port_in_range && slot_in_range);
   end

   for (genvar s = 0; s < int'(MAX_PORTS); s++) begin : g_slot
      logic [BITS_PER_SLOT-1:0] field_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  field_q <= '0;
         else if (upd_accept && slot_sel == SW'(s))   field_q <= upd_status;
      end
      assign pattern[BITS_PER_SLOT*s +: BITS_PER_SLOT] = field_q;
   end

endmodule

// File: rtl/sgpio_led_frame_seq.sv
module sgpio_led_frame_seq #(
   parameter int unsigned MAX_PORTS   = 8,
   parameter int unsigned PW          = 4,
   parameter int unsigned CNT_W       = 4,
   parameter int unsigned HALF_CYCLES = 2500
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_req,
   input  logic [3*MAX_PORTS-1:0]     pattern,
   input  logic [PW-1:0]              nports_eff,
   input  logic [CNT_W-1:0]           cfg_pre,
   input  logic [CNT_W-1:0]           cfg_post,
   output logic                       busy,
   output logic                       led_clk,
   output logic                       led_load,
   output logic                       led_data
);
   import sgpio_led_pkg::*;

   localparam int unsigned PAT_W  = 3 * MAX_PORTS;
   localparam int unsigned HCW    = (2*HALF_CYCLES > 1) ? $clog2(2*HALF_CYCLES) : 1;
   localparam int unsigned BCW    = $clog2(PAT_W + 1);
   localparam int unsigned ICW    = (CNT_W > BCW) ? CNT_W : BCW;

   frame_phase_t      phase;
   logic [HCW-1:0]    half_cnt;
   logic [ICW-1:0]    item_cnt;
   logic [PAT_W-1:0]  shreg;
   logic              pending;
   logic [ICW-1:0]    nbits;
   logic              cyc_last;

   assign nbits    = ICW'(nports_eff) * ICW'(3);
   assign cyc_last = (half_cnt == HCW'(2*HALF_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         half_cnt <= '0;
         item_cnt <= '0;
         shreg    <= '0;
         pending  <= 1'b0;
      end else begin
         pending <= pending | start_req;
         if (phase == PH_IDLE) begin
            if (pending) begin
               pending  <= start_req;
               shreg    <= pattern;
               half_cnt <= '0;
               if (cfg_pre != '0) begin
                  phase    <= PH_PRE;
                  item_cnt <= ICW'(cfg_pre) - ICW'(1);
               end else begin
                  phase    <= PH_LOAD;
               end
            end
         end else if (!cyc_last) begin
            half_cnt <= half_cnt + HCW'(1);
         end else begin
            half_cnt <= '0;
            case (phase)
               PH_PRE: begin
                  if (item_cnt == '0) phase <= PH_LOAD;
                  else                item_cnt <= item_cnt - ICW'(1);
               end
               PH_LOAD: begin
                  if (nbits != '0) begin
                     phase    <= PH_DATA;
                     item_cnt <= nbits - ICW'(1);
                  end else if (cfg_post != '0) begin
                     phase    <= PH_POST;
                     item_cnt <= ICW'(cfg_post) - ICW'(1);
                  end else begin
                     phase    <= PH_IDLE;
                  end
               end
               PH_DATA: begin
                  shreg <= shreg >> 1;
                  if (item_cnt != '0) begin
                     item_cnt <= item_cnt - ICW'(1);
                  end else if (cfg_post != '0) begin
                     phase    <= PH_POST;
                     item_cnt <= ICW'(cfg_post) - ICW'(1);
                  end else begin
                     phase    <= PH_IDLE;
                  end
               end
               PH_POST: begin
                  if (item_cnt == '0) phase <= PH_IDLE;
                  else                item_cnt <= item_cnt - ICW'(1);
               end
               default: phase <= PH_IDLE;
            endcase
         end
      end
   end

   assign busy     = (phase != PH_IDLE);
   assign led_clk  = !busy || (half_cnt >= HCW'(HALF_CYCLES));
   assign led_load = !busy || (phase == PH_LOAD);
   assign led_data = !busy || ((phase == PH_DATA) && shreg[0]);

endmodule

// File: rtl/sgpio_led_shifter.sv
module sgpio_led_shifter #(
   parameter int unsigned MAX_PORTS   = 8,
   parameter int unsigned CNT_W       = 4,
   parameter int unsigned HALF_CYCLES = 2500,
   parameter int unsigned PW          = $clog2(MAX_PORTS + 1),
   parameter int unsigned SW          = (MAX_PORTS > 1) ? $clog2(MAX_PORTS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       upd_valid,
   input  logic [PW-1:0]              upd_port,
   input  logic                       upd_act,
   input  logic                       upd_loc,
   input  logic                       upd_flt,
   input  logic [PW-1:0]              cfg_nports,
   input  logic [CNT_W-1:0]           cfg_pre,
   input  logic [CNT_W-1:0]           cfg_post,
   input  logic [MAX_PORTS*SW-1:0]    cfg_slot_map,
   output logic                       upd_err,
   output logic                       led_clk,
   output logic                       led_load,
   output logic                       led_data
);
   import sgpio_led_pkg::*;

   localparam int unsigned PAT_W = BITS_PER_SLOT * MAX_PORTS;

   if (MAX_PORTS < 1 || MAX_PORTS > 64) begin : g_chk_ports
      $error("MAX_PORTS must lie in 1..64");
   end
   if (HALF_CYCLES < 1) begin : g_chk_half
      $error("HALF_CYCLES must be at least 1");
   end
   if (CNT_W < 1) begin : g_chk_cnt
      $error("CNT_W must be at least 1");
   end

   logic [PW-1:0]    nports_eff;
   logic [PAT_W-1:0] pattern;
   logic             upd_accept;
   logic             frame_busy;
   logic [2:0]       upd_status;

   assign nports_eff = (cfg_nports > PW'(MAX_PORTS)) ? PW'(MAX_PORTS) : cfg_nports;

   always_comb begin
      upd_status          = '0;
      upd_status[BIT_ACT] = upd_act;
      upd_status[BIT_LOC] = upd_loc;
      upd_status[BIT_FLT] = upd_flt;
   end

   sgpio_led_pattern #(
      .MAX_PORTS (MAX_PORTS),
      .PW        (PW),
      .SW        (SW)
   ) u_pattern (
      .clk        (clk),
      .rst_n      (rst_n),
      .upd_valid  (upd_valid),
      .upd_port   (upd_port),
      .upd_status (upd_status),
      .nports_eff (nports_eff),
      .slot_map   (cfg_slot_map),
      .pattern    (pattern),
      .upd_accept (upd_accept),
      .upd_err    (upd_err)
   );

   sgpio_led_frame_seq #(
      .MAX_PORTS   (MAX_PORTS),
      .PW          (PW),
      .CNT_W       (CNT_W),
      .HALF_CYCLES (HALF_CYCLES)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_req  (upd_accept),
      .pattern    (pattern),
      .nports_eff (nports_eff),
      .cfg_pre    (cfg_pre),
      .cfg_post   (cfg_post),
      .busy       (frame_busy),
      .led_clk    (led_clk),
      .led_load   (led_load),
      .led_data   (led_data)
   );

endmodule

// File: rtl/sgpio_led_shifter_chk.sv
module sgpio_led_shifter_chk #(
   parameter int unsigned HALF_CYCLES = 2500
) (
   input logic clk,
   input logic rst_n,
   input logic upd_valid,
   input logic upd_accept,
   input logic upd_err,
   input logic busy,
   input logic led_clk,
   input logic led_load,
   input logic led_data
);
   int unsigned lo_run;
   int unsigned hi_run;
   int unsigned load_rises;
   logic        clk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_run     <= 0;
         hi_run     <= 0;
         load_rises <= 0;
         clk_q      <= 1'b1;
      end else begin
         clk_q  <= led_clk;
         lo_run <= led_clk ? 0 : lo_run + 1;
         hi_run <= led_clk ? hi_run + 1 : 0;
         if (!led_load)                load_rises <= 0;
         else if (led_clk && !clk_q)   load_rises <= load_rises + 1;
      end
   end

   // R1
   clk_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (led_clk && !clk_q) |-> (lo_run == HALF_CYCLES));

   // R1
   clk_high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!led_clk && clk_q && $past(busy)) |-> (hi_run == HALF_CYCLES));

   // R3
   load_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(led_load) && $past(busy)) |-> (load_rises == 1));

   // R4
   data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(led_clk) |-> ($stable(led_data) && $stable(led_load)));

   // R9
   err_only_on_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_err |-> ($past(upd_valid) && !$past(upd_accept)));

   // R10
   accept_starts_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_accept && !busy) |-> ##2 busy);

endmodule

bind sgpio_led_shifter sgpio_led_shifter_chk #(
   .HALF_CYCLES (HALF_CYCLES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .upd_valid  (upd_valid),
   .upd_accept (upd_accept),
   .upd_err    (upd_err),
   .busy       (frame_busy),
   .led_clk    (led_clk),
   .led_load   (led_load),
   .led_data   (led_data)
);

// File: tb/sgpio_led_shifter_tb.sv
module sgpio_led_shifter_tb;
   localparam int CLK_PERIOD = 10;
   localparam int MAXP  = 8;
   localparam int HALF  = 2;
   localparam int CW    = 3;
   localparam int PW    = 4;
   localparam int SW    = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic upd_valid = 1'b0;
   logic [PW-1:0] upd_port = '0;
   logic upd_act = 1'b0, upd_loc = 1'b0, upd_flt = 1'b0;
   logic [PW-1:0] cfg_nports = PW'(8);
   logic [CW-1:0] cfg_pre = '0, cfg_post = '0;
   logic [MAXP*SW-1:0] cfg_slot_map = '0;
   logic upd_err, led_clk, led_load, led_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   sgpio_led_shifter #(
      .MAX_PORTS (MAXP), .CNT_W (CW), .HALF_CYCLES (HALF)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .upd_valid (upd_valid), .upd_port (upd_port),
      .upd_act (upd_act), .upd_loc (upd_loc), .upd_flt (upd_flt),
      .cfg_nports (cfg_nports), .cfg_pre (cfg_pre), .cfg_post (cfg_post),
      .cfg_slot_map (cfg_slot_map), .upd_err (upd_err),
      .led_clk (led_clk), .led_load (led_load), .led_data (led_data)
   );

   int n_chk = 0;
   int n_err = 0;
   int rec_n = 0;
   logic rec_load [256];
   logic rec_data [256];
   int map_m [MAXP];
   logic [3*MAXP-1:0] mpat;
   int np, pre, post;

   // receiver: samples on each rising edge of the serial clock
   always @(posedge led_clk) begin
      if (rst_n && rec_n < 256) begin
         rec_load[rec_n] = led_load;
         rec_data[rec_n] = led_data;
         rec_n++;
      end
   end

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic apply_cfg(input int n, input int pr, input int po);
      np = n; pre = pr; post = po;
      cfg_nports = PW'(n);
      cfg_pre = CW'(pr);
      cfg_post = CW'(po);
      for (int p = 0; p < MAXP; p++) cfg_slot_map[p*SW +: SW] = SW'(map_m[p]);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      mpat = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      rec_n = 0;
   endtask

   function automatic int frame_len();
      return pre + 1 + 3*np + post;
   endfunction

   // compare one recorded frame starting at index base with pattern exp
   task automatic check_frame(input int base, input logic [3*MAXP-1:0] exp, input string tag);
      int bad_load = 0;
      int bad_data = 0;
      for (int i = 0; i < frame_len(); i++) begin
         logic el, ed;
         el = (i == pre);
         ed = (i > pre && i <= pre + 3*np) ? exp[i-pre-1] : 1'b0;
         if (rec_load[base+i] !== el) bad_load++;
         if (rec_data[base+i] !== ed) bad_data++;
      end
      chk(bad_load == 0, {"R2/R3 load sequence ", tag}, bad_load, 0);
      chk(bad_data == 0, {"R4 R6 R7 data bits ", tag}, bad_data, 0);
   endtask

   // drive one update, return whether it was rejected by the model
   task automatic send_update(input int port, input int st, output bit rejected);
      rejected = (port >= np) || (port >= MAXP) || (map_m[port] >= np);
      @(negedge clk);
      upd_valid = 1'b1;
      upd_port = PW'(port);
      upd_act = st[0]; upd_loc = st[1]; upd_flt = st[2];
      @(negedge clk);
      upd_valid = 1'b0;
      chk(upd_err === rejected, "R9 upd_err one cycle after request", int'(upd_err), int'(rejected));
      if (!rejected) mpat[3*map_m[port] +: 3] = st[2:0];
   endtask

   task automatic run_one(input int port, input int st, input string tag);
      bit rej;
      rec_n = 0;
      send_update(port, st, rej);
      repeat (frame_len()*2*HALF + 8) @(negedge clk);
      if (rej) begin
         chk(rec_n == 0, {"R9 no frame after reject ", tag}, rec_n, 0);
      end else begin
         chk(rec_n == frame_len(), {"R2 R5 clock count ", tag}, rec_n, frame_len());
         check_frame(0, mpat, tag);
         chk(led_clk && led_load && led_data, {"R5 lines high after frame ", tag},
             int'({led_clk, led_load, led_data}), 7);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
   end

   initial begin
      logic [3*MAXP-1:0] snap1;
      bit rej;
      for (int p = 0; p < MAXP; p++) map_m[p] = p;
      apply_cfg(8, 0, 0);
      do_reset();

      // R8: idle after reset
      repeat (40) @(negedge clk);
      chk(led_clk && led_load && led_data, "R8 lines high after reset",
          int'({led_clk, led_load, led_data}), 7);
      chk(rec_n == 0, "R8 no frame without update", rec_n, 0);

      // identity map, no extra clocks: every port x every status
      for (int p = 0; p < MAXP; p++)
         for (int s = 0; s < 8; s++) run_one(p, s, "identity");

      // reversed map with leading and trailing clocks
      for (int p = 0; p < MAXP; p++) map_m[p] = MAXP - 1 - p;
      apply_cfg(8, 2, 3);
      do_reset();
      for (int p = 0; p < MAXP; p++)
         for (int s = 0; s < 8; s++) run_one(p, (s + p) % 8, "reversed");

      // five ports in use, rotated map, maximal extra clocks; rejects included
      for (int p = 0; p < MAXP; p++) map_m[p] = (p + 3) % MAXP;
      apply_cfg(5, 7, 7);
      do_reset();
      for (int p = 0; p < 10; p++)
         for (int s = 1; s < 8; s += 3) run_one(p, s, "rotated");
      run_one(0, 6, "rotated after rejects");

      // R10 R11: updates during a frame
      for (int p = 0; p < MAXP; p++) map_m[p] = p;
      apply_cfg(4, 1, 1);
      do_reset();
      rec_n = 0;
      send_update(0, 7, rej);
      snap1 = mpat;
      repeat (20) @(negedge clk);
      send_update(1, 5, rej);
      send_update(2, 2, rej);
      repeat (2*frame_len()*2*HALF + 20) @(negedge clk);
      chk(rec_n == 2*frame_len(), "R10 exactly one extra frame", rec_n, 2*frame_len());
      check_frame(0, snap1, "R11 frame snapshot");
      check_frame(frame_len(), mpat, "R10 follow-up frame");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule